// File: doc/BRIEF.md
# Reconfiguration Engine Register Front-End

This block is the register file and control sequencer on the device side of a partial-reconfiguration engine. A host reaches it through a plain 64-bit memory-mapped port with separate read and write strobes. Through that port the host resets the engine with a request/acknowledge exchange and picks a target region. It opens a reconfiguration session and streams 32-bit configuration words into an internal queue, pacing itself by a free-entry credit shown in status. When it has sent everything, it signals that the push is finished and waits until the engine drops its busy flag.

The engine side of the queue is a simple sink port that takes one word per cycle while `sink_ready` is high. Three fault inputs from the reconfiguration fabric are recorded as sticky flags, next to the flags the front-end raises itself for pushes that break protocol and pushes that overflow the queue. The host clears flags by writing ones to them.

Top module: `recfg_front`

## Requirements
- R1: After reset, control and error read 0, status reads credit = DEPTH with the busy bit clear, and `sink_valid` and `bus_rvalid` are low.
- R2: Writing control bit 0 = 1 holds the engine in reset. Control bit 4 (acknowledge) rises one cycle after the request is stored and falls one cycle after it is cleared. While reset is held, the queue is emptied, start and complete are cleared, and the status controller code (bits 22:20) reads 1.
- R3: Control bits 9:7 hold a 3-bit region number that reads back as written, and the other control bits keep their values.
- R4: Writing control bit 12 = 1 outside reset starts a session. While it is set, status bit 16 reads 1, host code (bits 27:24) reads 1 and controller code reads 2. When idle, all three read 0.
- R5: Status bits 8:0 read DEPTH minus the number of stored words. An accepted data write lowers the credit by one.
- R6: A data write (offset 0x18) during a session stores bits 31:0. Stored words leave on `sink_data` in write order, one per cycle while `sink_ready` is high, with `sink_valid` one cycle after the pop.
- R7: A data write during a session while the queue is full is dropped and sets error bit 4.
- R8: A data write with no session open, or during reset, is dropped and sets error bit 3. Credit does not change.
- R9: Writing control bit 13 = 1 during a session marks the push complete. The controller code then reads 3, and once the queue is empty, the engine clears bits 12 and 13 and busy reads 0.
- R10: `fault_in` bits 0, 1 and 2 set error bits 0, 1 and 2 respectively, and all error bits stay set.
- R11: Writing the error register (offset 0x20) clears each bit written as 1. A fault arriving in the same cycle wins over the clear.
- R12: Offsets 0x00, 0xA8 and 0xB0 read the HDR_VALUE, IFID_LO and IFID_HI parameters, and writes to them change nothing. The data offset and unmapped offsets read 0.
- R13: A read strobe returns `bus_rdata` with `bus_rvalid` high on the next cycle, using register values from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| fault_in | input | 3 | Fabric fault pulses (operation, CRC, incompatible image) |
| sink_ready | input | 1 | Engine takes a queue word |
| sink_data | output | 32 | Configuration word to the engine |
| sink_valid | output | 1 | `sink_data` holds a word |

## Verification
Queue traffic is exercised in three patterns, each checked for word order and credit: pushes with the sink stalled, pushes while the sink drains, and a fill to exactly DEPTH followed by one extra word. The extra word separates a correct full test from an off-by-one, and the stalled case separates credit bookkeeping from draining. Pushes made before start and during reset tell the protocol-error path apart from the overflow path. A fault and a clear landing in the same cycle show which one has priority. A per-cycle model compares every read response and every sink word.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam int ADDR_W   = 8;
  localparam int RGN_W    = 3;
  localparam int CREDIT_W = 9;
  localparam int ERR_W    = 5;

  localparam logic [ADDR_W-1:0] OFS_HDR  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ERR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IDLO = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_IDHI = 8'hB0;

  // control bit positions
  localparam int CB_RST    = 0;
  localparam int CB_ACK    = 4;
  localparam int CB_RGN_LO = 7;
  localparam int CB_START  = 12;
  localparam int CB_DONE   = 13;
  // status bit positions
  localparam int SB_BUSY   = 16;
  localparam int SB_CCODE  = 20;
  localparam int SB_HCODE  = 24;
  // error bit positions
  localparam int EB_OPER   = 0;
  localparam int EB_CRC    = 1;
  localparam int EB_IMAGE  = 2;
  localparam int EB_PROTO  = 3;
  localparam int EB_OVF    = 4;

  typedef enum logic [2:0] {
    CC_IDLE   = 3'd0,
    CC_RESET  = 3'd1,
    CC_RUN    = 3'd2,
    CC_FINISH = 3'd3
  } ctl_code_e;

  typedef struct packed {
    logic             rst_req;
    logic             ack;
    logic [RGN_W-1:0] region;
    logic             start;
    logic             done;
  } ctl_state_t;
endpackage

// File: rtl/recfg_fifo.sv
module recfg_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      count     <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= pop;
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        count <= '0;
      end else begin
        if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
        case ({push, pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/recfg_ctrl.sv
module recfg_ctrl
  import recfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             data_wr,
  input  logic             err_wr,
  input  logic [63:0]      wdata,
  input  logic [2:0]       fault_in,
  input  logic             q_full,
  input  logic             q_empty,
  output ctl_state_t       st,
  output logic [ERR_W-1:0] err,
  output logic             push_ok,
  output logic             flush
);
  logic             in_session;
  logic [ERR_W-1:0] err_set, err_clr;

  assign in_session = st.start && !st.rst_req;
  assign flush      = st.rst_req;
  assign push_ok    = data_wr && in_session && !q_full;

  always_comb begin
    err_set           = '0;
    err_set[EB_OPER]  = fault_in[0];
    err_set[EB_CRC]   = fault_in[1];
    err_set[EB_IMAGE] = fault_in[2];
    err_set[EB_PROTO] = data_wr && !in_session;
    err_set[EB_OVF]   = data_wr && in_session && q_full;
    err_clr           = err_wr ? wdata[ERR_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
    end else begin
      err <= (err & ~err_clr) | err_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st.ack <= st.rst_req;
      if (st.rst_req) begin
        st.start <= 1'b0;
        st.done  <= 1'b0;
      end else if (st.start && st.done && q_empty) begin
        st.start <= 1'b0;
        st.done  <= 1'b0;
      end
      if (ctrl_wr) begin
        st.rst_req <= wdata[CB_RST];
        st.region  <= wdata[CB_RGN_LO +: RGN_W];
        if (wdata[CB_START] && !st.rst_req) st.start <= 1'b1;
        if (wdata[CB_DONE] && in_session)   st.done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/recfg_front.sv
module recfg_front
  import recfg_pkg::*;
#(
  parameter int          DEPTH     = 32,
  parameter logic [63:0] HDR_VALUE = 64'h3000_0000_1000_0005,
  parameter logic [63:0] IFID_LO   = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] IFID_HI   = 64'hFEDC_BA98_7654_3210,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [2:0]        fault_in,
  input  logic              sink_ready,
  output logic [31:0]       sink_data,
  output logic              sink_valid
);
  ctl_state_t       st;
  logic [ERR_W-1:0] err_q;
  logic [CW-1:0]    q_count;
  logic             q_full, q_empty, push_ok, flush, pop;
  logic             ctrl_wr, data_wr, err_wr;
  logic             rst_req_w, ack_w, start_w, done_w;
  logic [63:0]      rd_val;
  logic [2:0]       ccode;
  logic [3:0]       hcode;
  logic [CREDIT_W-1:0] credit;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign data_wr = bus_wr && (bus_addr == OFS_DATA);
  assign err_wr  = bus_wr && (bus_addr == OFS_ERR);
  assign pop     = sink_ready && !q_empty && !st.rst_req;

  recfg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .data_wr  (data_wr),
    .err_wr   (err_wr),
    .wdata    (bus_wdata),
    .fault_in (fault_in),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .st       (st),
    .err      (err_q),
    .push_ok  (push_ok),
    .flush    (flush)
  );

  recfg_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push_ok),
    .push_data (bus_wdata[31:0]),
    .pop       (pop),
    .pop_data  (sink_data),
    .pop_valid (sink_valid),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign rst_req_w = st.rst_req;
  assign ack_w     = st.ack;
  assign start_w   = st.start;
  assign done_w    = st.done;

  always_comb begin
    if (st.rst_req)    ccode = CC_RESET;
    else if (st.done)  ccode = CC_FINISH;
    else if (st.start) ccode = CC_RUN;
    else               ccode = CC_IDLE;
    hcode  = st.start ? 4'd1 : 4'd0;
    credit = CREDIT_W'(DEPTH) - CREDIT_W'(q_count);
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_HDR:  rd_val = HDR_VALUE;
      OFS_CTRL: begin
        rd_val[CB_RST]                 = st.rst_req;
        rd_val[CB_ACK]                 = st.ack;
        rd_val[CB_RGN_LO +: RGN_W]     = st.region;
        rd_val[CB_START]               = st.start;
        rd_val[CB_DONE]                = st.done;
      end
      OFS_STAT: begin
        rd_val[CREDIT_W-1:0]           = credit;
        rd_val[SB_BUSY]                = st.start;
        rd_val[SB_CCODE +: 3]          = ccode;
        rd_val[SB_HCODE +: 4]          = hcode;
      end
      OFS_ERR:  rd_val[ERR_W-1:0]      = err_q;
      OFS_IDLO: rd_val = IFID_LO;
      OFS_IDHI: rd_val = IFID_HI;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/recfg_front_chk.sv
module recfg_front_chk
  import recfg_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              sink_valid,
  input logic              rst_req,
  input logic              ack,
  input logic              start,
  input logic              done,
  input logic [CW-1:0]     count,
  input logic [ERR_W-1:0]  err
);
  logic wr_data, wr_ctrl, wr_err;
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_err  = bus_wr && (bus_addr == OFS_ERR);

  assert_rvalid_R13: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_no_stray_rvalid_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> ack);
  assert_ack_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !rst_req |=> !ack);
  assert_flush_R2: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (count == '0) && !start);
  assert_credit_range_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_data && start && !rst_req && count == CW'(DEPTH)) |=> err[EB_OVF]);
  assert_protocol_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !start) |=> err[EB_PROTO]);
  assert_finish_R9: assert property (@(posedge clk) disable iff (rst)
    (start && done && count == '0 && !rst_req && !wr_ctrl) |=> !start);
  assert_done_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> start);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_err |=> ((err & $past(err)) == $past(err)));
  assert_sink_source_R6: assert property (@(posedge clk) disable iff (rst)
    sink_valid |-> $past(count) != '0);
endmodule

bind recfg_front recfg_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .sink_valid (sink_valid),
  .rst_req    (rst_req_w),
  .ack        (ack_w),
  .start      (start_w),
  .done       (done_w),
  .count      (q_count),
  .err        (err_q)
);

// File: tb/sim_recfg_front.sv
module sim_recfg_front;
  localparam int          DEPTH = 32;
  localparam logic [63:0] HDR   = 64'h5A5A_0000_0000_00E1;
  localparam logic [63:0] IDL   = 64'h1111_2222_3333_4444;
  localparam logic [63:0] IDH   = 64'h5555_6666_7777_8888;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [2:0]  fault_in = '0;
  logic        sink_ready = 1'b0;
  logic [31:0] sink_data;
  logic        sink_valid;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  recfg_front #(.DEPTH(DEPTH), .HDR_VALUE(HDR), .IFID_LO(IDL), .IFID_HI(IDH)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .fault_in(fault_in), .sink_ready(sink_ready), .sink_data(sink_data),
    .sink_valid(sink_valid)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_rst, m_ack, m_start, m_done, m_rv, m_sv, m_live;
  bit [2:0]    m_rgn;
  bit [4:0]    m_err;
  bit [63:0]   m_rdv;
  bit [31:0]   m_sd;
  bit [31:0]   mq[$];

  function automatic bit [63:0] model_read(bit [7:0] a);
    bit [63:0] v = '0;
    case (a)
      8'h00: v = HDR;
      8'h08: v = {50'd0, m_done, m_start, 2'd0, m_rgn, 2'd0, m_ack, 3'd0, m_rst};
      8'h10: begin
        v[8:0]   = 9'(DEPTH - mq.size());
        v[16]    = m_start;
        v[22:20] = m_rst ? 3'd1 : m_done ? 3'd3 : m_start ? 3'd2 : 3'd0;
        v[27:24] = m_start ? 4'd1 : 4'd0;
      end
      8'h20: v = {59'd0, m_err};
      8'hA8: v = IDL;
      8'hB0: v = IDH;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    m_live = 1;
    if (rst) begin
      m_rst = 0; m_ack = 0; m_start = 0; m_done = 0; m_rgn = 0; m_err = 0;
      m_rv = 0; m_sv = 0; mq.delete();
    end else begin
      bit o_rst, o_start, o_done;
      int o_size;
      bit [4:0] set, clr;
      o_rst = m_rst; o_start = m_start; o_done = m_done; o_size = mq.size();
      m_rv = bus_rd;
      if (bus_rd) m_rdv = model_read(bus_addr);
      m_sv = 0;
      if (o_rst) mq.delete();
      else if (sink_ready && o_size > 0) begin m_sv = 1; m_sd = mq.pop_front(); end
      set = {2'b00, fault_in};
      if (bus_wr && bus_addr == 8'h18) begin
        if (!o_start || o_rst) set[3] = 1;
        else if (o_size == DEPTH) set[4] = 1;
        else mq.push_back(bus_wdata[31:0]);
      end
      clr = (bus_wr && bus_addr == 8'h20) ? bus_wdata[4:0] : 5'd0;
      m_err = (m_err & ~clr) | set;
      m_ack = o_rst;
      if (o_rst || (o_start && o_done && o_size == 0)) begin m_start = 0; m_done = 0; end
      if (bus_wr && bus_addr == 8'h08) begin
        m_rst = bus_wdata[0];
        m_rgn = bus_wdata[9:7];
        if (bus_wdata[12] && !o_rst) m_start = 1;
        if (bus_wdata[13] && o_start && !o_rst) m_done = 1;
      end
    end
  end

  bit [31:0] got[$];
  always @(negedge clk) begin
    if (m_live && !finished) begin
      total++;
      if (bus_rvalid !== m_rv || (m_rv && bus_rdata !== m_rdv)) begin
        bad++;
        $display("FAIL R13 model read: rvalid=%0b data=%h expected rvalid=%0b data=%h",
                 bus_rvalid, bus_rdata, m_rv, m_rdv);
      end
      total++;
      if (sink_valid !== m_sv || (m_sv && sink_data !== m_sd)) begin
        bad++;
        $display("FAIL R6 model sink: valid=%0b data=%h expected valid=%0b data=%h",
                 sink_valid, sink_data, m_sv, m_sd);
      end
      if (sink_valid === 1'b1) got.push_back(sink_data);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
    chk("R13 rvalid", {63'd0, bus_rvalid}, 64'd1);
  endtask

  function automatic logic [63:0] stat(int credit, int busy, int cc);
    return 64'(credit) | (64'(busy) << 16) | (64'(cc) << 20) | (64'(busy) << 24);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    bit [31:0] sent[$];
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 sink_valid", {63'd0, sink_valid}, 64'd0);
    chk("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
    rd(8'h08, v); chk("R1 ctrl", v, 64'd0);
    rd(8'h10, v); chk("R1 status", v, stat(DEPTH, 0, 0));
    rd(8'h20, v); chk("R1 err", v, 64'd0);
    rd(8'h00, v); chk("R12 header", v, HDR);
    rd(8'hA8, v); chk("R12 id low", v, IDL);
    rd(8'hB0, v); chk("R12 id high", v, IDH);
    rd(8'h28, v); chk("R12 unmapped", v, 64'd0);
    wr(8'h00, '1); wr(8'hA8, '0);
    rd(8'h00, v); chk("R12 header write ignored", v, HDR);
    rd(8'hA8, v); chk("R12 id write ignored", v, IDL);

    // push without session
    wr(8'h18, 64'hABCD);
    rd(8'h20, v); chk("R8 protocol bit", v, 64'h08);
    rd(8'h10, v); chk("R8 credit unchanged", v, stat(DEPTH, 0, 0));
    wr(8'h20, 64'h08);
    rd(8'h20, v); chk("R11 w1c", v, 64'd0);

    // reset handshake
    wr(8'h08, 64'h1);
    rd(8'h08, v); chk("R2 ack set", v, 64'h11);
    wr(8'h08, 64'h0);
    rd(8'h08, v); chk("R2 ack cleared", v, 64'h0);

    // region and start
    wr(8'h08, 64'(5) << 7);
    rd(8'h08, v); chk("R3 region", v, 64'h280);
    wr(8'h08, 64'h1280);
    rd(8'h08, v); chk("R3 region kept with start", v, 64'h1280);
    rd(8'h10, v); chk("R4 busy status", v, stat(DEPTH, 1, 2));

    // pushes with sink stalled, then drain
    got.delete();
    for (int i = 0; i < 3; i++) begin
      sent.push_back(32'hC0DE_0000 + 32'(i));
      wr(8'h18, {32'hFFFF_FFFF, 32'hC0DE_0000 + 32'(i)});
    end
    rd(8'h10, v); chk("R5 credit after 3", v, stat(DEPTH - 3, 1, 2));
    @(negedge clk); sink_ready = 1;
    for (int i = 0; i < 4; i++) begin
      sent.push_back(32'h5EED_0000 + 32'(i));
      wr(8'h18, 64'(32'h5EED_0000 + 32'(i)));
    end
    repeat (4) @(negedge clk);
    sink_ready = 0;
    chk("R6 word count", 64'(got.size()), 64'(sent.size()));
    for (int i = 0; i < sent.size() && i < got.size(); i++)
      chk("R6 order", 64'(got[i]), 64'(sent[i]));
    rd(8'h10, v); chk("R5 credit restored", v, stat(DEPTH, 1, 2));

    // fill to full and overflow
    for (int i = 0; i < DEPTH; i++) wr(8'h18, 64'(32'hF111_0000 + 32'(i)));
    rd(8'h10, v); chk("R5 credit zero", v, stat(0, 1, 2));
    wr(8'h18, 64'hDEAD);
    rd(8'h20, v); chk("R7 overflow bit", v, 64'h10);
    rd(8'h10, v); chk("R7 credit still zero", v, stat(0, 1, 2));

    // completion
    wr(8'h08, 64'h3280);
    rd(8'h08, v); chk("R9 complete held", v, 64'h3280);
    rd(8'h10, v); chk("R9 finishing code", v, stat(0, 1, 3));
    got.delete();
    @(negedge clk); sink_ready = 1;
    repeat (DEPTH + 6) @(negedge clk);
    sink_ready = 0;
    chk("R6 full drain count", 64'(got.size()), 64'(DEPTH));
    if (got.size() > 0) chk("R6 first drained", 64'(got[0]), 64'h F111_0000);
    rd(8'h08, v); chk("R9 start released", v, 64'h280);
    rd(8'h10, v); chk("R9 idle status", v, stat(DEPTH, 0, 0));

    // faults and clear priority
    wr(8'h20, 64'h1F);
    rd(8'h20, v); chk("R11 clear all", v, 64'd0);
    @(negedge clk); fault_in = 3'b101;
    @(negedge clk); fault_in = 3'b000;
    rd(8'h20, v); chk("R10 fault bits", v, 64'h05);
    @(negedge clk); fault_in = 3'b010;
    @(negedge clk); fault_in = 3'b000;
    rd(8'h20, v); chk("R10 crc bit sticky", v, 64'h07);
    @(negedge clk); fault_in = 3'b001; bus_wr = 1; bus_addr = 8'h20; bus_wdata = 64'h01;
    @(negedge clk); fault_in = 3'b000; bus_wr = 0;
    rd(8'h20, v); chk("R11 set wins", v, 64'h07);
    wr(8'h20, 64'h1F);
    rd(8'h20, v); chk("R11 cleared", v, 64'd0);

    // reset while a session holds data
    wr(8'h08, 64'h1280);
    wr(8'h18, 64'h1); wr(8'h18, 64'h2);
    rd(8'h10, v); chk("R5 credit two used", v, stat(DEPTH - 2, 1, 2));
    wr(8'h08, 64'h1281);
    repeat (2) @(negedge clk);
    rd(8'h10, v); chk("R2 flush status", v, stat(DEPTH, 0, 1));
    rd(8'h08, v); chk("R2 ctrl under reset", v, 64'h291);
    wr(8'h18, 64'h3);
    rd(8'h20, v); chk("R8 push during reset", v, 64'h08);
    wr(8'h08, 64'h280);
    repeat (2) @(negedge clk);
    rd(8'h08, v); chk("R2 released", v, 64'h280);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule